// File: doc/BRIEF.md
# Time-Slice Monitoring Snapshot Sequencer

This block gathers per-slice monitoring data for a bank of hit counters. Each input channel has a live counter that counts strobes on its hit line and stops at its maximum value rather than wrapping. When the time-slice start pulse arrives, the block copies every live count into a snapshot register. In the same cycle it clears the live counters, so they begin counting the new slice. The snapshots therefore always describe the slice that has just ended.

The same pulse latches an interrupt toward the embedded processor and sets a busy flag. The sequencer then streams a monitoring payload on a valid/ready interface. The payload is a header word with a slice sequence number, then every snapshot count, then a fixed section of a dual-port RAM that the processor filled during the slice just ended. Busy drops after the last word is accepted. The processor polls busy to learn when its RAM section has been drained and may be rewritten.

If a slice pulse arrives while the previous packet is still being sent, the block sets a sticky overrun flag and lets the running packet finish. It then takes the deferred snapshot and sends it as a complete packet of its own.

Top module: `slice_monitor`

## Requirements
- R1: After reset, irq, busy, overrun, outValid and outLast are all 0, and the first packet's header carries sequence number 0.
- R2: Each live counter adds one for every cycle its hitStb bit is high, and holds at all-ones (2^CNT_W-1) once reached.
- R3: On a snapshot, every live count is captured and the live counter restarts in that same cycle. A hit strobe in the snapshot cycle is not part of the capture and makes the new live count 1.
- R4: irq becomes 1 in the cycle after slicePulse is sampled high. It returns to 0 the cycle after irqClr is sampled high. If both are high in the same cycle, irq is set.
- R5: busy becomes 1 in the cycle after slicePulse is sampled high. It returns to 0 in the cycle after the final payload word is accepted, unless a deferred snapshot is waiting.
- R6: A packet is, in order: a header word whose low SEQ_W bits hold the sequence number (zero-extended), then the counts of channels 0 to NUM_CH-1 zero-extended in ascending order, then RAM words at addresses 0 to RAM_WORDS-1 in ascending order. The sequence number rises by one per snapshot.
- R7: outLast is 1 only on the final RAM word of a packet, and only while outValid is 1.
- R8: While outValid is 1 and outReady is 0, outValid, outData and outLast hold their values into the next cycle.
- R9: The header becomes valid in the cycle after the snapshot. With outReady held at 1, each count takes one cycle and each RAM word two cycles (one-cycle read latency, with ramRdEn and ramAddr presented the cycle before the word is valid). The last word is accepted NUM_CH+2*RAM_WORDS cycles after the header.
- R10: A slicePulse sampled while busy is 1 sets overrun, and overrun stays set until reset. The running packet completes unchanged, and the deferred snapshot is taken afterwards and sent as a full packet.
- R11: Any number of slice pulses during one busy period yields exactly one deferred snapshot and one extra packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hitStb | input | NUM_CH | Per-channel hit strobe, one count per high cycle |
| slicePulse | input | 1 | Time-slice start pulse |
| irqClr | input | 1 | Clears the interrupt flag |
| ramRdEn | output | 1 | Read enable to the dual-port RAM |
| ramAddr | output | RAM_AW | Read address within the monitoring section |
| ramRdData | input | WORD_W | Read data, valid one cycle after the read enable |
| outData | output | WORD_W | Payload word |
| outValid | output | 1 | Payload word valid |
| outLast | output | 1 | Marks the final word of a packet |
| outReady | input | 1 | Downstream accepts the word |
| irq | output | 1 | Latched interrupt toward the processor |
| busy | output | 1 | Transfer in progress or snapshot pending |
| overrun | output | 1 | Sticky flag: a slice pulse arrived while busy |

## Verification
The bench builds the block with five channels, four-bit counters and a three-word RAM section. A packet is then only nine words long, and a sweep of up to 21 hits per slice drives several channels past the counter ceiling of 15. Four consecutive slices use channel-dependent hit counts. These slices alternate between a free-running and a toggling ready, so packet content, the cycle timing, backpressure holding and the carry of a simultaneous hit into the next slice are all compared against counts worked out arithmetically. A stalled sink then lets repeated pulses arrive during a transfer, which exercises overrun and the single deferred packet.

// File: rtl/slice_mon_pkg.sv
package slice_mon_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_CNT,
    ST_RAMREQ,
    ST_RAMOUT
  } seqState_t;

  typedef enum logic [1:0] {
    SEL_HDR,
    SEL_CNT,
    SEL_RAM
  } outSel_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic    snap;
    outSel_t sel;
  } dpCtrl_t;

endpackage

// File: rtl/slice_mon_datapath.sv
module slice_mon_datapath
  import slice_mon_pkg::*;
#(
  parameter int NUM_CH = 31,
  parameter int CNT_W  = 16,
  parameter int WORD_W = 32,
  parameter int SEQ_W  = 16,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hitStb,
  input  dpCtrl_t           ctrl,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] ramRdData,
  output logic [WORD_W-1:0] outData
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] liveCnt [NUM_CH];
  logic [CNT_W-1:0] snapCnt [NUM_CH];
  logic [SEQ_W-1:0] seqCnt;
  logic [SEQ_W-1:0] snapSeq;
  logic [CNT_W-1:0] cntSel;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          liveCnt[ch] <= '0;
          snapCnt[ch] <= '0;
        end else if (ctrl.snap) begin
          snapCnt[ch] <= liveCnt[ch];
          liveCnt[ch] <= hitStb[ch] ? CNT_W'(1) : '0;
        end else if (hitStb[ch] && liveCnt[ch] != CNT_MAX) begin
          liveCnt[ch] <= liveCnt[ch] + CNT_W'(1);
        end
      end

      AST_SNAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.snap |=> (liveCnt[ch] == (($past(hitStb[ch])) ? CNT_W'(1) : '0))
                      && snapCnt[ch] == $past(liveCnt[ch])); // R3

      AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (liveCnt[ch] == CNT_MAX && !ctrl.snap) |=> liveCnt[ch] == CNT_MAX); // R2
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seqCnt  <= '0;
      snapSeq <= '0;
    end else if (ctrl.snap) begin
      snapSeq <= seqCnt;
      seqCnt  <= seqCnt + SEQ_W'(1);
    end
  end

  always_comb begin
    cntSel = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (idx == IDX_W'(ch)) cntSel = snapCnt[ch];
    end
  end

  always_comb begin
    case (ctrl.sel)
      SEL_HDR: outData = WORD_W'(snapSeq);
      SEL_CNT: outData = WORD_W'(cntSel);
      default: outData = ramRdData;
    endcase
  end

endmodule

// File: rtl/slice_mon_ctrl.sv
module slice_mon_ctrl
  import slice_mon_pkg::*;
#(
  parameter int NUM_CH    = 31,
  parameter int RAM_WORDS = 16,
  parameter int IDX_W     = 6,
  parameter int RAM_AW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slicePulse,
  input  logic              irqClr,
  input  logic              outReady,
  output dpCtrl_t           ctrl,
  output logic [IDX_W-1:0]  idx,
  output logic              outValid,
  output logic              outLast,
  output logic              ramRdEn,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              irq,
  output logic              busy,
  output logic              overrun
);

  localparam logic [IDX_W-1:0] LAST_CH  = IDX_W'(NUM_CH - 1);
  localparam logic [IDX_W-1:0] LAST_RAM = IDX_W'(RAM_WORDS - 1);

  seqState_t state;
  logic      pending;
  logic      startNow;

  assign startNow = (state == ST_IDLE) && (slicePulse || pending);
  assign busy     = (state != ST_IDLE) || pending;
  assign outValid = (state == ST_HDR) || (state == ST_CNT) || (state == ST_RAMOUT);
  assign outLast  = (state == ST_RAMOUT) && (idx == LAST_RAM);
  assign ramRdEn  = (state == ST_RAMREQ) || (state == ST_RAMOUT);
  assign ramAddr  = idx[RAM_AW-1:0];

  always_comb begin
    ctrl.snap = startNow;
    case (state)
      ST_HDR:  ctrl.sel = SEL_HDR;
      ST_CNT:  ctrl.sel = SEL_CNT;
      default: ctrl.sel = SEL_RAM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          idx <= '0;
          if (startNow) state <= ST_HDR;
        end
        ST_HDR: if (outReady) state <= ST_CNT;
        ST_CNT: if (outReady) begin
          if (idx == LAST_CH) begin
            state <= ST_RAMREQ;
            idx   <= '0;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        ST_RAMREQ: state <= ST_RAMOUT;
        ST_RAMOUT: if (outReady) begin
          if (idx == LAST_RAM) begin
            state <= ST_IDLE;
            idx   <= '0;
          end else begin
            state <= ST_RAMREQ;
            idx   <= idx + IDX_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      overrun <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (startNow)                             pending <= 1'b0;
      else if (slicePulse && state != ST_IDLE)  pending <= 1'b1;
      if (slicePulse && busy) overrun <= 1'b1;
      if (slicePulse)         irq <= 1'b1;
      else if (irqClr)        irq <= 1'b0;
    end
  end

  AST_IRQ_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    slicePulse |=> irq); // R4
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irqClr && !slicePulse) |=> !irq); // R4
  AST_BUSY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    slicePulse |=> busy); // R5
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (slicePulse && busy) |=> overrun); // R10
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R10
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    outLast |-> outValid); // R7
  AST_RAM_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RAMOUT && !$past(state == ST_RAMOUT)) |-> $past(ramRdEn) && $stable(ramAddr)); // R9

endmodule

// File: rtl/slice_monitor.sv
module slice_monitor
  import slice_mon_pkg::*;
#(
  parameter int NUM_CH    = 31,
  parameter int CNT_W     = 16,
  parameter int WORD_W    = 32,
  parameter int SEQ_W     = 16,
  parameter int RAM_WORDS = 16,
  localparam int MAX_N    = (NUM_CH > RAM_WORDS) ? NUM_CH : RAM_WORDS,
  localparam int IDX_W    = $clog2(MAX_N + 1),
  localparam int RAM_AW   = (RAM_WORDS > 1) ? $clog2(RAM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hitStb,
  input  logic              slicePulse,
  input  logic              irqClr,
  output logic              ramRdEn,
  output logic [RAM_AW-1:0] ramAddr,
  input  logic [WORD_W-1:0] ramRdData,
  output logic [WORD_W-1:0] outData,
  output logic              outValid,
  output logic              outLast,
  input  logic              outReady,
  output logic              irq,
  output logic              busy,
  output logic              overrun
);

  dpCtrl_t          ctrl;
  logic [IDX_W-1:0] idx;

  slice_mon_ctrl #(
    .NUM_CH(NUM_CH), .RAM_WORDS(RAM_WORDS), .IDX_W(IDX_W), .RAM_AW(RAM_AW)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .slicePulse(slicePulse), .irqClr(irqClr),
    .outReady(outReady), .ctrl(ctrl), .idx(idx), .outValid(outValid),
    .outLast(outLast), .ramRdEn(ramRdEn), .ramAddr(ramAddr), .irq(irq),
    .busy(busy), .overrun(overrun)
  );

  slice_mon_datapath #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .WORD_W(WORD_W), .SEQ_W(SEQ_W), .IDX_W(IDX_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .hitStb(hitStb), .ctrl(ctrl), .idx(idx),
    .ramRdData(ramRdData), .outData(outData)
  );

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> outValid && $stable(outData) && $stable(outLast)); // R8

endmodule

// File: tb/slice_monitor_tb_top.sv
module slice_monitor_tb_top;

  localparam int NC = 5;
  localparam int CW = 4;
  localparam int RW = 3;
  localparam int WW = 32;
  localparam int CMAX = (1 << CW) - 1;
  localparam int NW = 1 + NC + RW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] hitStb = '0;
  logic slicePulse = 1'b0;
  logic irqClr = 1'b0;
  logic ramRdEn;
  logic [1:0] ramAddr;
  logic [WW-1:0] ramRdData = '0;
  logic [WW-1:0] outData;
  logic outValid, outLast;
  logic outReady = 1'b1;
  logic irq, busy, overrun;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int readyMode = 0;
  int holdViol = 0;
  logic [WW-1:0] mem [RW];
  logic [WW-1:0] gotData [$];
  bit gotLast [$];
  int gotCyc [$];
  int expCnt [NC];
  int carry [NC];
  bit prevStall = 0;
  logic [WW-1:0] prevData;
  bit prevLast;

  always #5 clk = ~clk;

  slice_monitor #(.NUM_CH(NC), .CNT_W(CW), .WORD_W(WW), .SEQ_W(16), .RAM_WORDS(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hitStb(hitStb), .slicePulse(slicePulse), .irqClr(irqClr),
    .ramRdEn(ramRdEn), .ramAddr(ramAddr), .ramRdData(ramRdData), .outData(outData),
    .outValid(outValid), .outLast(outLast), .outReady(outReady), .irq(irq),
    .busy(busy), .overrun(overrun)
  );

  always @(posedge clk) begin
    if (ramRdEn) ramRdData <= mem[ramAddr];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    if (readyMode == 0) outReady = 1'b1;
    else if (readyMode == 1) outReady = (cyc % 3) != 0;
    else outReady = 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prevStall && (!outValid || outData !== prevData || outLast !== prevLast)) holdViol++;
      prevStall = outValid && !outReady;
      prevData = outData;
      prevLast = outLast;
      if (outValid && outReady) begin
        gotData.push_back(outData);
        gotLast.push_back(outLast);
        gotCyc.push_back(cyc);
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    finishRun();
  end

  task automatic waitWords(input int n);
    int t = 0;
    while (gotData.size() < n && t < 2000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic sendPulse(input logic [NC-1:0] mask, input bit clr);
    @(posedge clk); #2;
    slicePulse = 1'b1; hitStb = mask; irqClr = clr;
    @(posedge clk); #2;
    slicePulse = 1'b0; hitStb = '0; irqClr = 1'b0;
  endtask

  task automatic driveHits(input int nHit [NC]);
    for (int k = 0; k < 22; k++) begin
      @(posedge clk); #2;
      for (int c = 0; c < NC; c++) hitStb[c] = (k < nHit[c]);
    end
    @(posedge clk); #2;
    hitStb = '0;
  endtask

  // compare one packet at queue offset base
  task automatic checkPacket(input int base, input int seq, input int slice);
    check(gotData[base] == WW'(seq), "R6 header", gotData[base], seq);
    for (int c = 0; c < NC; c++)
      check(gotData[base+1+c] == WW'(expCnt[c]), "R2/R3/R6 count", gotData[base+1+c], expCnt[c]);
    for (int a = 0; a < RW; a++)
      check(gotData[base+1+NC+a] == WW'(slice*256 + a + 1), "R6 ram word",
            gotData[base+1+NC+a], slice*256 + a + 1);
    for (int w = 0; w < NW; w++)
      check(gotLast[base+w] == (w == NW-1), "R7 last marker", gotLast[base+w], w == NW-1);
  endtask

  initial begin
    int nHit [NC];
    for (int c = 0; c < NC; c++) carry[c] = 0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(!irq && !busy && !overrun && !outValid && !outLast, "R1 reset state",
          {irq, busy, overrun, outValid, outLast}, 0);

    // sweep four slices
    for (int s = 0; s < 4; s++) begin
      readyMode = s % 2;
      for (int a = 0; a < RW; a++) mem[a] = WW'(s*256 + a + 1);
      for (int c = 0; c < NC; c++) begin
        nHit[c] = (c*5 + s*3) % 22;
        expCnt[c] = (nHit[c] + carry[c] > CMAX) ? CMAX : nHit[c] + carry[c];
        carry[c] = 0;
      end
      driveHits(nHit);
      gotData.delete(); gotLast.delete(); gotCyc.delete();
      holdViol = 0;
      sendPulse((s == 1) ? NC'(1) : '0, s == 2);
      if (s == 1) carry[0] = 1;
      @(negedge clk);
      check(irq == 1'b1, "R4 irq set on pulse (set wins over clear)", irq, 1);
      check(busy == 1'b1, "R5 busy set on pulse", busy, 1);
      check(outValid == 1'b1 && outData == WW'(s), "R9 header valid after snapshot", outData, s);
      waitWords(NW);
      check(gotData.size() == NW, "R6 packet length", gotData.size(), NW);
      if (gotData.size() == NW) begin
        checkPacket(0, s, s);
        if (s % 2 == 0)
          check(gotCyc[NW-1] - gotCyc[0] == NC + 2*RW, "R9 transfer cycles",
                gotCyc[NW-1] - gotCyc[0], NC + 2*RW);
      end
      check(holdViol == 0, "R8 hold under stall", holdViol, 0);
      @(negedge clk);
      check(busy == 1'b0, "R5 busy cleared after last word", busy, 0);
      check(overrun == 1'b0, "R10 no overrun without overlap", overrun, 0);
      @(posedge clk); #2 irqClr = 1'b1;
      @(posedge clk); #2 irqClr = 1'b0;
      @(negedge clk);
      check(irq == 1'b0, "R4 irq cleared", irq, 0);
    end

    // overlap: pulses while busy with a stalled sink
    readyMode = 2;
    for (int a = 0; a < RW; a++) mem[a] = WW'(4*256 + a + 1);
    gotData.delete(); gotLast.delete(); gotCyc.delete();
    sendPulse('0, 0);
    for (int c = 0; c < NC; c++) nHit[c] = (c == 1) ? 3 : 0;
    driveHits(nHit);
    sendPulse('0, 0);
    sendPulse('0, 0);
    for (int c = 0; c < NC; c++) nHit[c] = (c == 2) ? 2 : 0;
    driveHits(nHit);
    @(negedge clk);
    check(overrun == 1'b1, "R10 overrun set", overrun, 1);
    check(busy == 1'b1 && gotData.size() == 0, "R10 stalled packet still pending", gotData.size(), 0);
    readyMode = 0;
    waitWords(2*NW);
    repeat (80) @(negedge clk);
    check(gotData.size() == 2*NW, "R11 exactly one deferred packet", gotData.size(), 2*NW);
    if (gotData.size() == 2*NW) begin
      for (int c = 0; c < NC; c++) expCnt[c] = carry[c];
      checkPacket(0, 4, 4);
      for (int c = 0; c < NC; c++) expCnt[c] = (c == 1) ? 3 : (c == 2) ? 2 : 0;
      checkPacket(NW, 5, 4);
    end
    check(overrun == 1'b1 && busy == 1'b0, "R10 overrun sticky, busy released",
          {overrun, busy}, 2);
    finishRun();
  end

endmodule